// File: doc/BRIEF.md
# Periodic Scan Sequencer with Overrun Watchdog

This block runs the fixed-period control scan of a programmable-logic-style controller. A periodic tick starts each scan. On that tick the block freezes every raw input line into a snapshot register, and the external logic engine reads that snapshot for the rest of the scan. The block then sends the engine a one-cycle start pulse and waits for its done. One cycle after done, the block copies the whole staged output word into the actuator register in a single load.

A watchdog counter restarts at the beginning of every scan. It measures the execute phase against a budget input that is given in clock cycles. Two events count as an overrun: the budget runs out before done arrives, or the next tick arrives while a scan is still running. An overrun aborts the scan without committing any output. It pulses an alert and sets a sticky fault. If shutdown is enabled, it also drives the actuators to a fixed safe value and blocks further scans until software asserts the clear input.

Top module: `scan_seq`

## Requirements
- R1: After reset, the snapshot is zero, the actuator word equals the safe value (parameter, default 0), and the start, alert, fault and shutdown outputs are low.
- R2: A tick sampled while the block is idle and not in shutdown loads the snapshot with `raw_in` at that edge. `exec_start` is then high for exactly the following cycle.
- R3: The snapshot keeps its value for the whole scan, whatever `raw_in` does.
- R4: When `exec_done` is sampled high during execute, the whole of `stage_in` appears on `act_out` one edge later. The actuator word changes only at a commit or on entry to shutdown.
- R5: Let B be the budget, with 0 treated as 1. If `exec_done` has not been seen by the B-th execute edge, that edge raises `overrun_alert` for exactly one cycle, ends the scan, and skips the commit.
- R6: A done sampled on the B-th execute cycle itself is in time: no alert, and the commit happens.
- R7: A tick sampled while a scan is executing or committing is an overrun. It starts no new scan and commits nothing.
- R8: `fault` goes high on any overrun and stays high until `fault_clr`. An overrun and a clear on the same edge leave it set.
- R9: An overrun with `shutdown_en` high sets `shutdown` and drives `act_out` to the safe value on the same edge. While `shutdown` is high, ticks start no scan and leave the snapshot unchanged. `fault_clr` ends shutdown, and `act_out` stays safe until the next commit.
- R10: An overrun with `shutdown_en` low leaves `act_out` at its last committed value, and later ticks start scans as normal.
- R11: `exec_done` has no effect while no scan is executing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_tick | input | 1 | Periodic scan-start tick |
| raw_in | input | IN_W | Raw input lines |
| snap_out | output | IN_W | Frozen input snapshot for the engine |
| exec_start | output | 1 | One-cycle start pulse to the engine |
| exec_done | input | 1 | Engine finished |
| stage_in | input | OUT_W | Staged output word from the engine |
| act_out | output | OUT_W | Committed actuator word |
| budget | input | BUD_W | Execute budget in cycles |
| shutdown_en | input | 1 | Overrun escalates to shutdown |
| fault_clr | input | 1 | Clears fault and shutdown |
| overrun_alert | output | 1 | One-cycle overrun pulse |
| fault | output | 1 | Sticky overrun flag |
| shutdown | output | 1 | Safe-state hold |

## Verification
Table-driven scans vary the done latency against the budget: done well inside the budget, done on the last allowed cycle, done one cycle late, and done never. These cases separate an off-by-one watchdog from a correct one, and they also test budgets of 0 and 1. Each scan has its own input and staged patterns, and `raw_in` is inverted mid-scan, so a snapshot that tracks the live inputs, a partial commit, or a commit after an abort each shows up as a wrong value. Directed cases then cover a late tick, done while idle, ticks during shutdown, recovery after clear, and an overrun that coincides with a clear.

// File: rtl/scan_seq_pkg.sv
`timescale 1ns/1ps
package scan_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_EXEC   = 2'd1,
    PH_COMMIT = 2'd2
  } phase_e;

  // Budget is spent once the cycle being counted is the last one allowed.
  // A zero budget behaves like a budget of one cycle.
  function automatic logic wd_expired(input logic [31:0] cnt, input logic [31:0] bud);
    return (cnt + 32'd1) >= bud;
  endfunction

  function automatic logic [31:0] wd_bump(input logic [31:0] cnt);
    return cnt + 32'd1;
  endfunction

endpackage

// File: rtl/scan_snapshot.sv
`timescale 1ns/1ps
module scan_snapshot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R3: the snapshot only moves on a load edge
  p_snap_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> $past(load));

endmodule

// File: rtl/scan_watchdog.sv
`timescale 1ns/1ps
module scan_watchdog #(
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic [BW-1:0] budget,
  output logic [BW-1:0] count,
  output logic          expired
);
  import scan_seq_pkg::*;

  logic [31:0] bumped;

  assign bumped  = wd_bump(32'(count));
  assign expired = wd_expired(32'(count), 32'(budget));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (run)   count <= bumped[BW-1:0];
  end

  // R5: every scan starts its budget from zero
  p_wd_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));

endmodule

// File: rtl/scan_out_commit.sv
`timescale 1ns/1ps
module scan_out_commit #(
  parameter int         W    = 16,
  parameter logic [W-1:0] SAFE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         force_safe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= SAFE;
    else if (force_safe) q <= SAFE;
    else if (load)       q <= d;
  end

  // R4: the actuator word moves only on a commit or a safe-state entry
  p_act_only_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> $past(load || force_safe));

  // R9: a safe-state entry always lands the safe value
  p_force_safe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_safe |=> (q == SAFE));

endmodule

// File: rtl/scan_seq.sv
`timescale 1ns/1ps
module scan_seq #(
  parameter int               IN_W     = 16,
  parameter int               OUT_W    = 16,
  parameter int               BUD_W    = 16,
  parameter logic [OUT_W-1:0] SAFE_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_tick,
  input  logic [IN_W-1:0]  raw_in,
  output logic [IN_W-1:0]  snap_out,
  output logic             exec_start,
  input  logic             exec_done,
  input  logic [OUT_W-1:0] stage_in,
  output logic [OUT_W-1:0] act_out,
  input  logic [BUD_W-1:0] budget,
  input  logic             shutdown_en,
  input  logic             fault_clr,
  output logic             overrun_alert,
  output logic             fault,
  output logic             shutdown
);
  import scan_seq_pkg::*;

  phase_e            phase_q, phase_d;
  logic [BUD_W-1:0]  wd_count;
  logic              wd_spent;

  // Named internal events
  logic scan_begin, late_tick, budget_miss, overrun_ev;
  logic done_ok, commit_ev, shut_entry, in_exec;

  assign in_exec     = (phase_q == PH_EXEC);
  assign scan_begin  = (phase_q == PH_IDLE) && scan_tick && !shutdown;
  assign late_tick   = (phase_q != PH_IDLE) && scan_tick;
  assign budget_miss = in_exec && !exec_done && wd_spent;
  assign overrun_ev  = late_tick || budget_miss;
  assign done_ok     = in_exec && exec_done && !overrun_ev;
  assign commit_ev   = (phase_q == PH_COMMIT) && !late_tick;
  assign shut_entry  = overrun_ev && shutdown_en;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (scan_begin) phase_d = PH_EXEC;
      PH_EXEC:   if (overrun_ev) phase_d = PH_IDLE;
                 else if (done_ok) phase_d = PH_COMMIT;
      PH_COMMIT: phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q       <= PH_IDLE;
      exec_start    <= 1'b0;
      overrun_alert <= 1'b0;
      fault         <= 1'b0;
      shutdown      <= 1'b0;
    end else begin
      phase_q       <= phase_d;
      exec_start    <= scan_begin;
      overrun_alert <= overrun_ev;
      if (overrun_ev)     fault <= 1'b1;
      else if (fault_clr) fault <= 1'b0;
      if (shut_entry)     shutdown <= 1'b1;
      else if (fault_clr) shutdown <= 1'b0;
    end
  end

  scan_snapshot #(.W(IN_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .load(scan_begin), .d(raw_in), .q(snap_out)
  );

  scan_watchdog #(.BW(BUD_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .clear(scan_begin), .run(in_exec),
    .budget(budget), .count(wd_count), .expired(wd_spent)
  );

  scan_out_commit #(.W(OUT_W), .SAFE(SAFE_VAL)) u_out (
    .clk(clk), .rst_n(rst_n), .load(commit_ev), .force_safe(shut_entry),
    .d(stage_in), .q(act_out)
  );

  // R2: start is a single-cycle pulse
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> !exec_start);

  // R5: the watchdog sits at zero in the first execute cycle
  p_wd_zero_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> (wd_count == '0));

  // R5: the alert never lasts two cycles
  p_alert_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_alert |=> !overrun_alert);

  // R4: a commit is always preceded by execution
  p_commit_after_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_COMMIT) |-> ($past(phase_q) == PH_EXEC));

  // R8: the fault holds without a clear
  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_clr) |=> fault);

  // R9: no scan starts and the outputs stay safe in shutdown
  p_shut_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (!exec_start && act_out == SAFE_VAL));

  // R7: a late tick never opens a new scan
  p_late_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    late_tick |=> (!exec_start && phase_q == PH_IDLE));

endmodule

// File: tb/scan_seq_tb.sv
`timescale 1ns/1ps
module scan_seq_tb;

  localparam int IN_W  = 16;
  localparam int OUT_W = 16;
  localparam int BUD_W = 16;
  localparam logic [OUT_W-1:0] SAFE = 16'h0000;

  typedef struct packed {
    logic [15:0] raw;
    logic [15:0] stg;
    logic [15:0] bud;
    logic [7:0]  dly;   // done arrives in this execute cycle; 0 = never
    logic        shen;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'hA5A5, 16'h1234, 16'd5, 8'd3, 1'b0},
    '{16'h5A5A, 16'hBEEF, 16'd4, 8'd4, 1'b0},
    '{16'hFFFF, 16'h0F0F, 16'd4, 8'd5, 1'b0},
    '{16'h0001, 16'h8001, 16'd1, 8'd1, 1'b0},
    '{16'h0000, 16'h7777, 16'd0, 8'd1, 1'b0},
    '{16'h1357, 16'h2468, 16'd3, 8'd0, 1'b1},
    '{16'hC3C3, 16'hCAFE, 16'd6, 8'd6, 1'b0},
    '{16'h8000, 16'h0042, 16'd2, 8'd3, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             scan_tick = 1'b0;
  logic [IN_W-1:0]  raw_in = '0;
  logic [IN_W-1:0]  snap_out;
  logic             exec_start;
  logic             exec_done = 1'b0;
  logic [OUT_W-1:0] stage_in = '0;
  logic [OUT_W-1:0] act_out;
  logic [BUD_W-1:0] budget = '0;
  logic             shutdown_en = 1'b0;
  logic             fault_clr = 1'b0;
  logic             overrun_alert;
  logic             fault;
  logic             shutdown;

  int n_chk = 0;
  int n_err = 0;
  logic [OUT_W-1:0] exp_act = SAFE;

  always #5 clk = ~clk;

  scan_seq #(.IN_W(IN_W), .OUT_W(OUT_W), .BUD_W(BUD_W), .SAFE_VAL(SAFE)) u_dut (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .raw_in(raw_in),
    .snap_out(snap_out), .exec_start(exec_start), .exec_done(exec_done),
    .stage_in(stage_in), .act_out(act_out), .budget(budget),
    .shutdown_en(shutdown_en), .fault_clr(fault_clr),
    .overrun_alert(overrun_alert), .fault(fault), .shutdown(shutdown)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    scan_tick = 1'b1;
    step();
    scan_tick = 1'b0;
  endtask

  task automatic clear_fault();
    fault_clr = 1'b1;
    step();
    fault_clr = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int  beff;
    bit  ovr;
    beff = (v.bud == 0) ? 1 : int'(v.bud);
    ovr  = (v.dly == 0) || (int'(v.dly) > beff);
    raw_in = v.raw; stage_in = v.stg; budget = v.bud; shutdown_en = v.shen;
    pulse_tick();
    chk(exec_start == 1'b1, "R2 start", 32'(exec_start), 1);
    chk(snap_out == v.raw, "R2 snapshot", 32'(snap_out), 32'(v.raw));
    raw_in = ~v.raw;
    if (!ovr) begin
      for (int i = 1; i <= int'(v.dly); i++) begin
        if (i == int'(v.dly)) exec_done = 1'b1;
        step();
        exec_done = 1'b0;
      end
      chk(overrun_alert == 1'b0, "R6 no alert", 32'(overrun_alert), 0);
      chk(act_out == exp_act, "R4 not yet", 32'(act_out), 32'(exp_act));
      chk(snap_out == v.raw, "R3 frozen", 32'(snap_out), 32'(v.raw));
      step();
      exp_act = v.stg;
      chk(act_out == exp_act, "R4 commit", 32'(act_out), 32'(exp_act));
    end else begin
      for (int i = 1; i <= beff; i++) begin
        if (i == beff) chk(overrun_alert == 1'b0, "R5 early", 32'(overrun_alert), 0);
        step();
      end
      chk(overrun_alert == 1'b1, "R5 alert", 32'(overrun_alert), 1);
      chk(fault == 1'b1, "R8 fault", 32'(fault), 1);
      chk(snap_out == v.raw, "R3 frozen", 32'(snap_out), 32'(v.raw));
      if (v.shen) begin
        exp_act = SAFE;
        chk(shutdown == 1'b1, "R9 shutdown", 32'(shutdown), 1);
      end
      chk(act_out == exp_act, "R5 R10 no commit", 32'(act_out), 32'(exp_act));
      step();
      chk(overrun_alert == 1'b0, "R5 pulse", 32'(overrun_alert), 0);
      chk(fault == 1'b1, "R8 sticky", 32'(fault), 1);
      chk(act_out == exp_act, "R10 hold", 32'(act_out), 32'(exp_act));
      clear_fault();
      chk(fault == 1'b0 && shutdown == 1'b0, "R8 clear", {fault, shutdown}, 0);
      chk(act_out == exp_act, "R9 stay safe", 32'(act_out), 32'(exp_act));
    end
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(snap_out == '0 && exec_start == 1'b0, "R1 reset snap/start", 32'(snap_out), 0);
    chk(act_out == SAFE, "R1 reset act", 32'(act_out), 32'(SAFE));
    chk({overrun_alert, fault, shutdown} == 3'b000, "R1 reset flags",
        {overrun_alert, fault, shutdown}, 0);
    rst_n = 1'b1;
    step();

    foreach (VECS[k]) run_vec(VECS[k]);

    // R7: tick while executing aborts without commit; R11: idle done ignored
    stage_in = 16'h9999; budget = 16'd10; shutdown_en = 1'b0; raw_in = 16'h0F00;
    pulse_tick();
    step();
    pulse_tick();
    chk(overrun_alert == 1'b1, "R7 late tick alert", 32'(overrun_alert), 1);
    chk(exec_start == 1'b0, "R7 no restart", 32'(exec_start), 0);
    chk(act_out == exp_act, "R7 no commit", 32'(act_out), 32'(exp_act));
    exec_done = 1'b1;
    step(); step();
    exec_done = 1'b0;
    step();
    chk(act_out == exp_act, "R11 idle done", 32'(act_out), 32'(exp_act));
    chk(exec_start == 1'b0, "R11 no start", 32'(exec_start), 0);
    clear_fault();

    // R9: ticks ignored while shut down, then recovery
    budget = 16'd1; shutdown_en = 1'b1; raw_in = 16'h1111;
    pulse_tick();
    step();
    chk(shutdown == 1'b1, "R9 entered", 32'(shutdown), 1);
    exp_act = SAFE;
    raw_in = 16'h2222;
    pulse_tick();
    chk(exec_start == 1'b0, "R9 tick ignored", 32'(exec_start), 0);
    chk(snap_out == 16'h1111, "R9 snap kept", 32'(snap_out), 32'h1111);
    chk(act_out == SAFE, "R9 act safe", 32'(act_out), 32'(SAFE));
    clear_fault();
    shutdown_en = 1'b0; stage_in = 16'h3C3C; budget = 16'd3;
    pulse_tick();
    chk(snap_out == 16'h2222, "R9 recovered scan", 32'(snap_out), 32'h2222);
    exec_done = 1'b1;
    step();
    exec_done = 1'b0;
    step();
    exp_act = 16'h3C3C;
    chk(act_out == exp_act, "R9 recovered commit", 32'(act_out), 32'(exp_act));
    step();

    // R8: overrun and clear on the same edge leave the fault set
    budget = 16'd2;
    pulse_tick();
    step();
    fault_clr = 1'b1;
    step();
    fault_clr = 1'b0;
    chk(fault == 1'b1, "R8 set wins", 32'(fault), 1);
    chk(act_out == exp_act, "R10 kept", 32'(act_out), 32'(exp_act));
    clear_fault();
    chk(fault == 1'b0, "R8 cleared", 32'(fault), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule